// File: doc/BRIEF.md
# Wake-Cause and Watchdog Warning Flag Block

This block keeps the sticky status bits that tell firmware why the core came out of sleep, and warns it that the watchdog is about to force a reset. A push-button input and a wake-timer timeout each latch their own flag. A free-running watchdog counter, restarted by a kick, raises a warning flag a fixed number of cycles before it emits a one-cycle reset pulse.

Firmware clears any flag by writing a zero to its bit through a small register port. Writing a one leaves the flag alone. The warning flag also clears itself when the WAKE level falls. The warning flag, once enabled by a control bit, drives an interrupt request that can be merged into a shared interrupt line.

Top module: `wake_watch_flags`

## Requirements
- R1: While rst_ni is low, all flags, the enable bit, wdog_rst_o, irq_o and reg_rdata_o are zero.
- R2: button_i passes through a two-flop synchronizer and is edge detected. The button flag sets on the third rising clock edge after button_i rises. Each press sets it once, and it sets whether or not wake_i is high.
- R3: When wake_tmo_i is high before a clock edge, the wake-timer flag is set after that edge.
- R4: A write with reg_addr_i=0 clears each flag whose data bit is zero: bit 0 is the button flag, bit 1 the wake-timer flag, bit 2 the warning flag. A data bit of one leaves its flag unchanged.
- R5: Without kicks, the warning flag sets exactly WARN_LEAD cycles before wdog_rst_o rises. This is the edge where the counter reaches WDOG_TIMEOUT-WARN_LEAD.
- R6: The counter starts at 0 after reset and after each kick. wdog_rst_o pulses high for one cycle on the edge where the counter would pass WDOG_TIMEOUT-1, and the counter restarts at 0. A kick on that edge suppresses the pulse.
- R7: A falling edge of wake_i, seen between two consecutive clock samples, clears the warning flag. It does not affect the other flags.
- R8: irq_o is high exactly when the warning flag and the enable bit are both high. The enable bit is bit 0 of the register at reg_addr_i=1 and is written directly.
- R9: If a hardware set and a clear (by write or by the WAKE falling edge) hit one flag in the same cycle, the flag ends up set.
- R10: reg_rdata_o returns {0, warning, wake-timer, button} at address 0 and {000, enable} at address 1, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| button_i | input | 1 | Asynchronous push-button level |
| wake_tmo_i | input | 1 | Wake-timer timeout strobe |
| wake_i | input | 1 | WAKE level (synchronous) |
| wdog_kick_i | input | 1 | Watchdog restart |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 flags, 1 control |
| reg_wdata_i | input | 4 | Write data |
| reg_rdata_o | output | 4 | Read data for reg_addr_i |
| btn_flag_o | output | 1 | Push-button flag |
| wake_flag_o | output | 1 | Wake-timer flag |
| warn_flag_o | output | 1 | Watchdog near-overflow flag |
| wdog_rst_o | output | 1 | One-cycle watchdog reset pulse |
| irq_o | output | 1 | Enabled warning interrupt request |

## Verification
Two events can reach a flag in the same cycle: a hardware set and a clear. The set comes from a button edge, a wake-timer strobe or the watchdog warning point. The clear is a zero-write, or a WAKE falling edge on the warning flag. The bench sweeps the delay between a button press or watchdog restart and a clearing write or WAKE fall across several cycles, so one offset in each sweep lands on the set edge. A behavioural model, compared every cycle, expects the flag to stay set in that case.

// File: rtl/wwf_pkg.sv
package wwf_pkg;
  localparam int unsigned REG_W = 4;
  localparam int unsigned FLAG_BTN  = 0;
  localparam int unsigned FLAG_WAKE = 1;
  localparam int unsigned FLAG_WARN = 2;

  typedef struct packed {
    logic warn;
    logic wake;
    logic btn;
  } flags_t;

  typedef enum logic {
    ADDR_FLAGS = 1'b0,
    ADDR_CTRL  = 1'b1
  } reg_addr_e;
endpackage

// File: rtl/wwf_btn_edge.sv
module wwf_btn_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[i] <= 1'b0;
          else         sync_q[i] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[i] <= 1'b0;
          else         sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;

  AST_SINGLE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R2
endmodule

// File: rtl/wwf_wdog.sv
module wwf_wdog #(
  parameter int unsigned WDOG_TIMEOUT = 40,
  parameter int unsigned WARN_LEAD    = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic warn_set_o,
  output logic rst_pulse_o
);
  localparam int unsigned CW = (WDOG_TIMEOUT > 1) ? $clog2(WDOG_TIMEOUT) : 1;
  localparam logic [CW-1:0] LAST_VAL = CW'(WDOG_TIMEOUT - 1);
  localparam logic [CW-1:0] WARN_PRE = CW'(WDOG_TIMEOUT - WARN_LEAD - 1);

  logic [CW-1:0] cnt_q;
  logic          rst_q;
  logic          at_last;

  assign at_last    = (cnt_q == LAST_VAL);
  assign warn_set_o = (cnt_q == WARN_PRE) & ~kick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rst_q <= 1'b0;
    end else begin
      rst_q <= at_last & ~kick_i;
      if (kick_i || at_last) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rst_pulse_o = rst_q;

  AST_RST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pulse_o |=> !rst_pulse_o); // R6
  AST_KICK_NO_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> !rst_pulse_o); // R6
endmodule

// File: rtl/wwf_flag_regs.sv
module wwf_flag_regs
  import wwf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             btn_set_i,
  input  logic             wake_set_i,
  input  logic             warn_set_i,
  input  logic             wake_i,
  input  logic             we_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output flags_t           flags_o,
  output logic             irq_en_o,
  output logic [REG_W-1:0] rdata_o
);
  flags_t flags_q;
  flags_t clr;
  logic   en_q;
  logic   wake_q;
  logic   wake_fall;

  always_comb begin
    clr = '0;
    if (we_i && reg_addr_e'(addr_i) == ADDR_FLAGS) begin
      clr.btn  = ~wdata_i[FLAG_BTN];
      clr.wake = ~wdata_i[FLAG_WAKE];
      clr.warn = ~wdata_i[FLAG_WARN];
    end
  end

  assign wake_fall = wake_q & ~wake_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      en_q    <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      wake_q       <= wake_i;
      flags_q.btn  <= btn_set_i  | (flags_q.btn  & ~clr.btn);
      flags_q.wake <= wake_set_i | (flags_q.wake & ~clr.wake);
      flags_q.warn <= warn_set_i | (flags_q.warn & ~clr.warn & ~wake_fall);
      if (we_i && reg_addr_e'(addr_i) == ADDR_CTRL) en_q <= wdata_i[0];
    end
  end

  always_comb begin
    if (reg_addr_e'(addr_i) == ADDR_CTRL) rdata_o = {{(REG_W-1){1'b0}}, en_q};
    else                                  rdata_o = {{(REG_W-3){1'b0}}, flags_q};
  end

  assign flags_o  = flags_q;
  assign irq_en_o = en_q;

  AST_BTN_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    btn_set_i |=> flags_q.btn); // R9
  AST_WARN_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_set_i |=> flags_q.warn); // R9
  AST_WRITE_ONE_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !addr_i && wdata_i[FLAG_WAKE] && !wake_set_i)
      |=> flags_q.wake == $past(flags_q.wake)); // R4
  AST_FALL_CLEARS_WARN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_fall && !warn_set_i) |=> !flags_q.warn); // R7
endmodule

// File: rtl/wake_watch_flags.sv
module wake_watch_flags
  import wwf_pkg::*;
#(
  parameter int unsigned WDOG_TIMEOUT = 40,
  parameter int unsigned WARN_LEAD    = 8,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             button_i,
  input  logic             wake_tmo_i,
  input  logic             wake_i,
  input  logic             wdog_kick_i,
  input  logic             reg_we_i,
  input  logic             reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             btn_flag_o,
  output logic             wake_flag_o,
  output logic             warn_flag_o,
  output logic             wdog_rst_o,
  output logic             irq_o
);
  logic   btn_rise;
  logic   warn_set;
  logic   irq_en;
  flags_t flags;

  wwf_btn_edge #(.SYNC_STAGES(SYNC_STAGES)) u_btn (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(button_i),
    .rise_o (btn_rise)
  );

  wwf_wdog #(.WDOG_TIMEOUT(WDOG_TIMEOUT), .WARN_LEAD(WARN_LEAD)) u_wdog (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .kick_i     (wdog_kick_i),
    .warn_set_o (warn_set),
    .rst_pulse_o(wdog_rst_o)
  );

  wwf_flag_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .btn_set_i (btn_rise),
    .wake_set_i(wake_tmo_i),
    .warn_set_i(warn_set),
    .wake_i    (wake_i),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .flags_o   (flags),
    .irq_en_o  (irq_en),
    .rdata_o   (reg_rdata_o)
  );

  assign btn_flag_o  = flags.btn;
  assign wake_flag_o = flags.wake;
  assign warn_flag_o = flags.warn;
  assign irq_o       = flags.warn & irq_en;

  AST_IRQ_NEEDS_WARN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> warn_flag_o); // R8
endmodule

// File: tb/wake_watch_flags_bench.sv
module wake_watch_flags_bench;
  localparam int T = 40;
  localparam int L = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       button = 0, wake_tmo = 0, wake = 0, kick = 0, we = 0, addr = 0;
  logic [3:0] wdata = 4'h0;
  logic [3:0] rdata;
  logic       btn_f, wake_f, warn_f, wrst, irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wake_watch_flags #(.WDOG_TIMEOUT(T), .WARN_LEAD(L)) u_wake_watch_flags (
    .clk_i(clk), .rst_ni(rst_n), .button_i(button), .wake_tmo_i(wake_tmo),
    .wake_i(wake), .wdog_kick_i(kick), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .btn_flag_o(btn_f),
    .wake_flag_o(wake_f), .warn_flag_o(warn_f), .wdog_rst_o(wrst), .irq_o(irq)
  );

  // behavioural reference
  bit m_sync[$];
  bit m_prev, m_btn, m_wake, m_warn, m_en, m_wq, m_rst;
  int m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = '{0, 0};
      m_prev = 0; m_btn = 0; m_wake = 0; m_warn = 0; m_en = 0; m_wq = 0;
      m_rst = 0; m_cnt = 0;
    end else begin
      bit rise, wclr, fall, wset;
      rise = m_sync[1] && !m_prev;
      wclr = we && !addr;
      fall = m_wq && !wake;
      wset = (m_cnt == T - L - 1) && !kick;
      m_prev = m_sync[1];
      void'(m_sync.pop_back());
      m_sync.push_front(button);
      m_btn  = rise || (m_btn && !(wclr && !wdata[0]));
      m_wake = wake_tmo || (m_wake && !(wclr && !wdata[1]));
      m_warn = wset || (m_warn && !(wclr && !wdata[2]) && !fall);
      if (we && addr) m_en = wdata[0];
      m_wq  = wake;
      m_rst = (m_cnt == T - 1) && !kick;
      m_cnt = (kick || m_cnt == T - 1) ? 0 : m_cnt + 1;
    end
  end

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%0b expected=%0b", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      logic [3:0] er;
      er = addr ? {3'b0, m_en} : {1'b0, m_warn, m_wake, m_btn};
      if (!rst_n) begin
        chk("R1 flags", btn_f | wake_f | warn_f, 1'b0);
        chk("R1 rst/irq", wrst | irq, 1'b0);
        chk("R1 rdata", |rdata, 1'b0);
      end else begin
        chk("R2 btn_flag", btn_f, m_btn);
        chk("R3 wake_flag", wake_f, m_wake);
        chk("R5/R7/R9 warn_flag", warn_f, m_warn);
        chk("R6 wdog_rst", wrst, m_rst);
        chk("R8 irq", irq, m_warn && m_en);
        checks++;
        if (rdata !== er) begin
          fails++;
          $display("FAIL R10 rdata t=%0t actual=%h expected=%h", $time, rdata, er);
        end
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic a, logic [3:0] d);
    we = 1; addr = a; wdata = d;
    cyc(1);
    we = 0; addr = 0; wdata = 0;
  endtask

  task automatic do_kick;
    kick = 1; cyc(1); kick = 0;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: run hung");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(2);
    // R2: single press, long hold, sets once; clearing while held does not re-set
    button = 1; cyc(2);
    chk("R2 not yet", btn_f, 1'b0);
    cyc(1);
    chk("R2 set third edge", btn_f, 1'b1);
    wr(0, 4'b1110); cyc(4);
    chk("R2 once per press", btn_f, 1'b0);
    button = 0; cyc(3);
    // R2: press while awake
    wake = 1; button = 1; cyc(3);
    chk("R2 awake press", btn_f, 1'b1);
    button = 0; cyc(3);
    // R4: write ones keeps, zeros clear
    wake_tmo = 1; cyc(1); wake_tmo = 0;
    chk("R3 wake set", wake_f, 1'b1);
    wr(0, 4'b0111); cyc(1);
    chk("R4 write one keeps", btn_f & wake_f, 1'b1);
    wr(0, 4'b0101); cyc(1);
    chk("R4 clear wake only", wake_f, 1'b0);
    chk("R4 btn kept", btn_f, 1'b1);
    // R9: button set vs clear sweep
    for (int d = 0; d < 5; d++) begin
      wr(0, 4'b0000);
      button = 1; cyc(d); wr(0, 4'b0000); cyc(3); button = 0; cyc(3);
    end
    // R9: wake_tmo set vs clear same cycle
    wake_tmo = 1; we = 1; wdata = 0; cyc(1); wake_tmo = 0; we = 0;
    chk("R9 wake set wins", wake_f, 1'b1);
    // R8: enable irq, let watchdog run
    wr(1, 4'b0001);
    do_kick;
    cyc(T - L);
    chk("R5 warn at lead", warn_f, 1'b1);
    chk("R8 irq", irq, 1'b1);
    chk("R6 no rst yet", wrst, 1'b0);
    cyc(L);
    chk("R6 rst pulse", wrst, 1'b1);
    cyc(1);
    chk("R6 one cycle", wrst, 1'b0);
    // R7: WAKE fall clears warn only
    wake = 1; cyc(2); wake = 0; cyc(1);
    chk("R7 fall clears", warn_f, 1'b0);
    wr(1, 4'b0000);
    // R9/R7: warn set vs fall and vs write sweeps
    for (int d = T - L - 3; d < T - L + 2; d++) begin
      wake = 1; do_kick; cyc(d - 1); wake = 0; cyc(L + 6);
      do_kick; cyc(d); wr(0, 4'b0000); cyc(3);
    end
    // R6: kick at terminal suppresses reset
    do_kick; cyc(T - 1); do_kick;
    chk("R6 kick suppresses", wrst, 1'b0);
    cyc(2 * T + 5);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule